// File: doc/BRIEF.md
# Flash Page Array Program/Erase Engine

This block is the storage array that sits behind a raw flash command interface. It holds a number of pages. Each page has a main data area and a spare area that is one thirty-second of the main size, so a 256-byte page carries 8 spare bytes, a 512-byte page carries 16 and a 2048-byte page carries 64. The command logic fills a write buffer and then starts one of three operations, selected by `op`:

- A **load** copies a whole page, main and spare, into a read buffer.
- A **program** merges the buffered bytes into a page with a bitwise AND. It starts at a column offset, so a bit can only move from one to zero.
- An **erase** returns every byte of an aligned group of pages to 0xFF.

After reset the engine sweeps the whole array to 0xFF before it accepts a start. Every operation keeps `busy` high while it walks the bytes and then for a further programmable number of cycles. It then raises `done` for one cycle. Program and erase need the `unlocked` input high; a request made while it is low does nothing and raises `err`. A request for a page index past the end of the array is ignored.

Top module: `nand_array_engine`

## Requirements
- R1: After reset the engine is busy, with `done` and `err` low, until every byte of every page, spare included, has been set to 0xFF. A load of any page then returns 0xFF in all `PAGE_BYTES + PAGE_BYTES/32` bytes.
- R2: A program (op = 1) with `unlocked` high replaces each addressed byte with the old value AND the buffered byte, so it never sets a bit that is already cleared.
- R3: Buffered byte i is merged at column `col + i` of the page. Bytes of the page below `col` are left unchanged, and bytes that would land at or past `PAGE_BYTES + PAGE_BYTES/32` are discarded.
- R4: After `wb_clr`, the write buffer takes at most `PAGE_BYTES + PAGE_BYTES/32` bytes through `wb_we`/`wb_din`. Later bytes are dropped and do not overwrite earlier ones.
- R5: The spare area holds `PAGE_BYTES/32` bytes per page, at columns `PAGE_BYTES` and up. It is loaded with the page and can be programmed like the main area.
- R6: An erase (op = 2) with `unlocked` high sets all bytes, spare included, of the `2**ERASE_SHIFT` pages whose index matches `page` with its low `ERASE_SHIFT` bits cleared. All other pages are left unchanged.
- R7: A program or erase started while `unlocked` is low changes no array byte and sets `err`. `err` then holds until the next accepted start, and an accepted start that is not blocked clears it.
- R8: A start whose `page` is at or beyond `NUM_PAGES` changes neither the array nor the read buffer, and leaves `err` low.
- R9: Every accepted start keeps `busy` high for at least `lat + 1` cycles. `done` then pulses for exactly one cycle, in the last busy cycle, and `busy` is low in the next cycle.
- R10: A start pulse that arrives while `busy` is high is ignored.
- R11: A load (op = 0) fills the read buffer with the page, and `rb_dout` shows byte `rb_addr` of the buffer combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the 0xFF sweep |
| start | input | 1 | Starts the operation in `op` when idle |
| op | input | 2 | 0 load, 1 program, 2 erase, 3 no operation |
| page | input | $clog2(NUM_PAGES)+1 | Page index |
| col | input | $clog2(PPS) | Program column offset |
| unlocked | input | 1 | High allows program and erase |
| lat | input | LAT_W | Extra busy cycles per operation |
| wb_clr | input | 1 | Empties the write buffer (program setup) |
| wb_we | input | 1 | Appends `wb_din` to the write buffer |
| wb_din | input | 8 | Write buffer data |
| rb_addr | input | $clog2(PPS) | Read buffer byte select |
| rb_dout | output | 8 | Read buffer byte |
| busy | output | 1 | Operation or initial sweep in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Last accepted program/erase was blocked |

## Verification
A wrong byte address or a wrong merge shows up in the array, but it is only visible at the ports after a later load copies the page into the read buffer. The bench therefore follows each program or erase with full-page loads, both of the target page and of neighbouring pages. A wrong erase alignment or a wrapping write buffer shows up as damaged bytes in pages or columns that should not have changed. A wrong sequencer state shows on `busy` and `done` within the same operation, and a stuck `err` shows at the next accepted start.

// File: rtl/nand_array_engine.sv
module nand_array_engine #(
  parameter int PAGE_BYTES  = 256,
  parameter int NUM_PAGES   = 8,
  parameter int ERASE_SHIFT = 2,
  parameter int LAT_W       = 8,
  localparam int PPS = PAGE_BYTES + PAGE_BYTES / 32,
  localparam int CW  = $clog2(PPS),
  localparam int PGW = $clog2(NUM_PAGES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [PGW-1:0]   page,
  input  logic [CW-1:0]    col,
  input  logic             unlocked,
  input  logic [LAT_W-1:0] lat,
  input  logic             wb_clr,
  input  logic             wb_we,
  input  logic [7:0]       wb_din,
  input  logic [CW-1:0]    rb_addr,
  output logic [7:0]       rb_dout,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int TOTAL = NUM_PAGES * PPS;
  localparam int MAW   = $clog2(TOTAL);
  localparam int IW    = $clog2(PPS << ERASE_SHIFT) + 1;
  localparam logic [1:0] OP_LOAD = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2;

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_WALK, S_LAT, S_DONE} st_t;
  st_t state;

  logic [7:0] mem  [TOTAL];
  logic [7:0] wbuf [PPS];
  logic [7:0] rbuf [PPS];

  logic [MAW-1:0]   base, s_base, waddr;
  logic [IW-1:0]    idx, len, colq, wcnt, s_len, pofs;
  logic [1:0]       opq;
  logic [LAT_W-1:0] lcnt;
  logic [PGW-1:0]   blk_page;
  logic             in_rng, blocked, walking, mem_we, rb_we, wb_take;
  logic [7:0]       wdata;

  assign in_rng   = page < PGW'(NUM_PAGES);
  assign blocked  = (op == OP_PROG || op == OP_ERASE) && !unlocked;
  assign blk_page = page & ~PGW'((1 << ERASE_SHIFT) - 1);
  assign s_base   = MAW'(op == OP_ERASE ? blk_page : page) * MAW'(PPS);
  assign s_len    = op == OP_LOAD ? IW'(PPS) :
                    op == OP_PROG ? wcnt : IW'(PPS << ERASE_SHIFT);
  assign wb_take  = wb_we && !wb_clr && wcnt < IW'(PPS);

  assign pofs    = colq + idx;
  assign walking = state == S_WALK && idx != len;
  assign mem_we  = state == S_INIT ||
                   (walking && (opq == OP_ERASE || (opq == OP_PROG && pofs < IW'(PPS))));
  assign rb_we   = walking && opq == OP_LOAD;
  assign waddr   = state == S_INIT ? base :
                   opq == OP_PROG ? base + MAW'(pofs) : base + MAW'(idx);
  assign wdata   = (state == S_WALK && opq == OP_PROG) ?
                   (mem[waddr] & wbuf[idx[CW-1:0]]) : 8'hFF;

  assign busy    = state != S_IDLE;
  assign done    = state == S_DONE;
  assign rb_dout = rbuf[rb_addr];

  always_ff @(posedge clk) begin
    if (mem_we) mem[waddr] <= wdata;
    if (rb_we) rbuf[idx[CW-1:0]] <= mem[waddr];
    if (wb_take) wbuf[wcnt[CW-1:0]] <= wb_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_INIT;
      base  <= '0;
      idx   <= '0;
      len   <= '0;
      colq  <= '0;
      opq   <= OP_LOAD;
      lcnt  <= '0;
      err   <= 1'b0;
      wcnt  <= '0;
    end else begin
      if (wb_clr) wcnt <= '0;
      else if (wb_take) wcnt <= wcnt + 1'b1;
      case (state)
        S_INIT: begin
          base <= base + 1'b1;
          if (base == MAW'(TOTAL - 1)) state <= S_IDLE;
        end
        S_IDLE: if (start) begin
          err   <= blocked && in_rng;
          opq   <= op;
          base  <= s_base;
          len   <= s_len;
          colq  <= IW'(col);
          idx   <= '0;
          lcnt  <= '0;
          state <= (in_rng && !blocked && op != 2'd3) ? S_WALK : S_LAT;
        end
        S_WALK: begin
          if (idx == len) state <= S_LAT;
          else idx <= idx + 1'b1;
        end
        S_LAT: begin
          if (lcnt == lat) state <= S_DONE;
          else lcnt <= lcnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_array_engine_chk.sv
module nand_array_engine_chk #(
  parameter int PGW = 4,
  parameter int NUM_PAGES = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [1:0]     op,
  input logic [PGW-1:0] page,
  input logic           unlocked,
  input logic           busy,
  input logic           done,
  input logic           err
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  // R9
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy || !start) |=> $stable(err));
  // R7
  blocked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !unlocked && (op == 2'd1 || op == 2'd2) && page < PGW'(NUM_PAGES)) |=> err);
  // R8
  range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && page >= PGW'(NUM_PAGES)) |=> !err);
endmodule

bind nand_array_engine nand_array_engine_chk #(.PGW(PGW), .NUM_PAGES(NUM_PAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .page(page), .unlocked(unlocked),
  .busy(busy), .done(done), .err(err)
);

// File: tb/nand_array_engine_tb.sv
`timescale 1ns/1ps
module nand_array_engine_tb_top;
  localparam int PAGE_BYTES = 256, NUM_PAGES = 8, ES = 2;
  localparam int PPS = PAGE_BYTES + PAGE_BYTES / 32;
  localparam int CW = $clog2(PPS);
  localparam int PGW = $clog2(NUM_PAGES) + 1;
  localparam int TOTAL = NUM_PAGES * PPS;

  logic clk = 0, rst_n = 0, start = 0, unlocked = 1, wb_clr = 0, wb_we = 0;
  logic [1:0] op = 0;
  logic [PGW-1:0] page = 0;
  logic [CW-1:0] col = 0, rb_addr = 0;
  logic [7:0] lat = 3, wb_din = 0, rb_dout;
  logic busy, done, err;

  logic [7:0] expm [TOTAL];
  logic [7:0] lastrb [PPS];
  logic [7:0] wbm [PPS];
  int wn;
  int n_chk = 0, n_fail = 0, ndone, nbusy;

  always #2.5 clk = ~clk;

  nand_array_engine #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .ERASE_SHIFT(ES)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .page(page), .col(col),
    .unlocked(unlocked), .lat(lat), .wb_clr(wb_clr), .wb_we(wb_we), .wb_din(wb_din),
    .rb_addr(rb_addr), .rb_dout(rb_dout), .busy(busy), .done(done), .err(err));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input int pg, input int c);
    @(negedge clk);
    op = o; page = PGW'(pg); col = CW'(c); start = 1;
    @(negedge clk);
    start = 0; ndone = 0; nbusy = 0;
    while (busy) begin
      if (done) ndone++;
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic wb_reset();
    @(negedge clk); wb_clr = 1; @(negedge clk); wb_clr = 0; wn = 0;
  endtask

  task automatic wb_push(input logic [7:0] d);
    wb_we = 1; wb_din = d; @(negedge clk); wb_we = 0;
    if (wn < PPS) begin wbm[wn] = d; wn++; end
  endtask

  task automatic prog(input int pg, input int c, input int n, input int seed);
    wb_reset();
    for (int i = 0; i < n; i++) wb_push(8'((seed * 29) ^ (i * 53) ^ (i >> 3)));
    run_op(2'd1, pg, c);
    if (unlocked && pg < NUM_PAGES)
      for (int i = 0; i < wn; i++)
        if (c + i < PPS) expm[pg * PPS + c + i] &= wbm[i];
  endtask

  task automatic erase(input int pg);
    run_op(2'd2, pg, 0);
    if (unlocked && pg < NUM_PAGES)
      for (int i = (pg >> ES) << ES; i < (((pg >> ES) + 1) << ES); i++)
        for (int j = 0; j < PPS; j++) expm[i * PPS + j] = 8'hFF;
  endtask

  task automatic load_cmp(input int pg, input string req);
    int bad = -1;
    logic [7:0] ev, av, e0, a0;
    run_op(2'd0, pg, 0);
    e0 = 0; a0 = 0;
    for (int i = 0; i < PPS; i++) begin
      rb_addr = CW'(i); #0.1;
      ev = (pg < NUM_PAGES) ? expm[pg * PPS + i] : lastrb[i];
      av = rb_dout;
      if (av !== ev && bad < 0) begin bad = i; e0 = ev; a0 = av; end
      lastrb[i] = av;
    end
    chk(bad < 0, req, $sformatf("page %0d byte %0d", pg, bad), a0, e0);
  endtask

  task automatic t_reset();
    #1;
    chk(busy === 1'b1, "R1", "busy during sweep", busy, 1);
    chk(done === 1'b0 && err === 1'b0, "R1", "done/err after reset", {done, err}, 0);
    while (busy) @(negedge clk);
    load_cmp(0, "R1");
    load_cmp(NUM_PAGES - 1, "R1");
  endtask

  task automatic t_program_and();
    prog(2, 5, 20, 3);
    load_cmp(2, "R3");
    prog(2, 9, 20, 11);
    load_cmp(2, "R2");
  endtask

  task automatic t_spare();
    prog(3, PAGE_BYTES - 2, 12, 7);
    load_cmp(3, "R5");
    prog(1, PPS - 3, 10, 5);
    load_cmp(1, "R3");
  endtask

  task automatic t_overflow();
    wb_reset();
    for (int i = 0; i < PPS + 36; i++) wb_push(i < PPS ? 8'hA5 : 8'h00);
    run_op(2'd1, 5, 0);
    for (int i = 0; i < PPS; i++) expm[5 * PPS + i] &= 8'hA5;
    load_cmp(5, "R4");
  endtask

  task automatic t_erase();
    prog(6, 0, 30, 9);
    erase(5);
    load_cmp(4, "R6");
    load_cmp(6, "R6");
    load_cmp(3, "R6");
    load_cmp(2, "R6");
  endtask

  task automatic t_protect();
    unlocked = 0;
    prog(2, 0, 16, 13);
    chk(err === 1'b1, "R7", "err after blocked program", err, 1);
    load_cmp(2, "R7");
    chk(err === 1'b0, "R7", "err cleared by accepted load", err, 0);
    erase(2);
    chk(err === 1'b1, "R7", "err after blocked erase", err, 1);
    unlocked = 1;
    load_cmp(2, "R7");
    chk(err === 1'b0, "R7", "err cleared", err, 0);
  endtask

  task automatic t_range();
    prog(9, 0, 8, 2);
    chk(err === 1'b0, "R8", "err on out-of-range program", err, 0);
    load_cmp(0, "R8");
    load_cmp(12, "R8");
    erase(13);
    load_cmp(1, "R8");
  endtask

  task automatic t_handshake();
    lat = 5;
    run_op(2'd3, 0, 0);
    chk(ndone == 1, "R9", "done pulses (nop)", ndone, 1);
    chk(nbusy >= 6, "R9", "busy cycles (nop)", nbusy, 6);
    lat = 17;
    load_cmp(1, "R11");
    chk(ndone == 1, "R9", "done pulses (load)", ndone, 1);
    chk(nbusy >= 18, "R9", "busy cycles (load)", nbusy, 18);
    lat = 3;
  endtask

  task automatic t_busy_ignore();
    lat = 40;
    @(negedge clk);
    op = 2'd0; page = 0; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); @(negedge clk);
    op = 2'd2; page = 0; start = 1;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    lat = 3;
    load_cmp(2, "R10");
  endtask

  initial begin
    for (int i = 0; i < TOTAL; i++) expm[i] = 8'hFF;
    for (int i = 0; i < PPS; i++) lastrb[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program_and();
    t_spare();
    t_overflow();
    t_erase();
    t_protect();
    t_range();
    t_handshake();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule